// File: doc/BRIEF.md
# Vertical Resampling Phase Accumulator and Line Fetch Planner

This block tracks where a vertical resampling filter sits in the source image from one output line to the next. It holds a fixed-point fraction register that gains a programmable step at every line strobe. From that step it decides how many new source lines must be brought in before the next output line can be filtered. The filter window keeps five source lines resident. The step has an integer part and a fractional part. The number of new lines is the integer part of the step plus the carry out of the fractional sum. That carry is known before the register is written, so the phase presented for the current line is the value held before the update. No integer line position is stored; the line address register does that job.

A frame-start pulse loads the line address register with the base address of the frame's top resident line and clears the fraction. After each strobe the block presents four results:
- the phase, which is the top fraction bits and selects the filter coefficients;
- the count of lines to fetch;
- an action code;
- the address of the first line to fetch.

A memory sequencer consumes these results and performs the transfers. Lines are always fetched consecutively from the given address.

Top module: `vscale_fetch_planner`

## Requirements
- R1: After reset, phase_o, count_o, action_o and fetch_addr_o are all zero, and plan_valid_o is low.
- R2: The phase_o value presented for a strobe is the top 5 bits of the 16-bit fraction held before that strobe's addition.
- R3: Each accepted strobe replaces the fraction with (fraction + inc_frac) mod 2^16. Cycles with neither a strobe nor a frame start leave it unchanged.
- R4: count_o equals inc_int plus the carry out of the 16-bit fraction addition, giving a range of 0 to 16.
- R5: When the count is 0, action_o is 0, meaning all resident lines are reused and nothing is fetched.
- R6: When the count is 1 to 4, action_o is 1. fetch_addr_o is then the line address plus 5 times the stride, which is the line just below the current window.
- R7: When the count is 5 or more, action_o is 2. fetch_addr_o is then the line address plus count times the stride, which is the top of the new window.
- R8: Each accepted strobe advances the line address by count times the stride, modulo 2^32.
- R9: frame_start loads the line address with base_addr and clears the fraction. It overrides a strobe in the same cycle, and that strobe produces no plan.
- R10: plan_valid_o pulses high for exactly one cycle per accepted strobe. All plan outputs hold their values between accepted strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Load line address from base_addr and clear fraction |
| line_stb | input | 1 | Advance one output line |
| inc_int | input | 4 | Integer part of the vertical step |
| inc_frac | input | 16 | Fractional part of the vertical step |
| base_addr | input | 32 | Address of the frame's top resident line |
| stride | input | 32 | Address distance between source lines |
| phase_o | output | 5 | Coefficient phase for the current line |
| count_o | output | 5 | Number of lines to fetch |
| action_o | output | 2 | 0 reuse, 1 fetch next sequential, 2 jump |
| fetch_addr_o | output | 32 | Address of the first line to fetch |
| plan_valid_o | output | 1 | One-cycle pulse when a new plan is presented |

## Verification
A strobe sampled on a rising edge produces its whole plan in output registers written on that same edge. The bench therefore raises line_stb at a falling edge, drops it at the next falling edge, and reads every output at that second falling edge, one half period after the registers change. A frame start has no output of its own. Its effects on the fraction and the line address are checked through the phase and address of the first strobe that follows it. Holding behaviour is checked by waiting several idle cycles and reading the outputs again.

// File: rtl/vsp_pkg.sv
package vsp_pkg;
  typedef enum logic [1:0] {
    ACT_REUSE = 2'd0,
    ACT_NEXT  = 2'd1,
    ACT_JUMP  = 2'd2
  } act_e;
endpackage

// File: rtl/vsp_phase_acc.sv
module vsp_phase_acc #(
  parameter int INT_W   = 4,
  parameter int FRAC_W  = 16,
  parameter int PHASE_W = 5,
  localparam int CNT_W  = INT_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic               restart,
  input  logic [INT_W-1:0]   inc_int,
  input  logic [FRAC_W-1:0]  inc_frac,
  output logic [PHASE_W-1:0] phase,
  output logic [CNT_W-1:0]   count
);
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W:0]   sum;

  assign sum   = {1'b0, frac_q} + {1'b0, inc_frac};
  // carry predicts the fetch count before the register is written
  assign count = {1'b0, inc_int} + CNT_W'(sum[FRAC_W]);
  assign phase = frac_q[FRAC_W-1 -: PHASE_W];

  always_ff @(posedge clk) begin
    if (rst || restart) frac_q <= '0;
    else if (step)      frac_q <= sum[FRAC_W-1:0];
  end

  assert_frac_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!step && !restart) |=> $stable(frac_q));
  assert_frac_clear_R9: assert property (@(posedge clk) disable iff (rst)
    restart |=> (frac_q == '0));
endmodule

// File: rtl/vsp_fetch_decide.sv
module vsp_fetch_decide #(
  parameter int CNT_W = 5,
  parameter int TAPS  = 5
) (
  input  logic [CNT_W-1:0] count,
  output vsp_pkg::act_e    act
);
  import vsp_pkg::*;
  always_comb begin
    if (count == '0)                act = ACT_REUSE;
    else if (count < CNT_W'(TAPS))  act = ACT_NEXT;
    else                            act = ACT_JUMP;
  end
endmodule

// File: rtl/vsp_addr_gen.sv
module vsp_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 5,
  parameter int TAPS   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              restart,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] jump_addr,
  output logic [ADDR_W-1:0] seq_addr
);
  logic [ADDR_W-1:0] line_q;
  logic [ADDR_W-1:0] acc [CNT_W+1];
  logic [ADDR_W-1:0] advance;

  // shift-add product of count and stride
  assign acc[0] = '0;
  for (genvar i = 0; i < CNT_W; i++) begin : g_pp
    assign acc[i+1] = acc[i] + (count[i] ? (stride << i) : '0);
  end
  assign advance   = acc[CNT_W];
  assign jump_addr = line_q + advance;
  assign seq_addr  = line_q + ADDR_W'(TAPS) * stride;

  always_ff @(posedge clk) begin
    if (rst)          line_q <= '0;
    else if (restart) line_q <= base;
    else if (step)    line_q <= line_q + advance;
  end

  assert_base_load_R9: assert property (@(posedge clk) disable iff (rst)
    restart |=> (line_q == $past(base)));
  assert_line_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!step && !restart) |=> $stable(line_q));
endmodule

// File: rtl/vscale_fetch_planner.sv
module vscale_fetch_planner #(
  parameter int INT_W   = 4,
  parameter int FRAC_W  = 16,
  parameter int PHASE_W = 5,
  parameter int ADDR_W  = 32,
  parameter int TAPS    = 5,
  localparam int CNT_W  = INT_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_start,
  input  logic               line_stb,
  input  logic [INT_W-1:0]   inc_int,
  input  logic [FRAC_W-1:0]  inc_frac,
  input  logic [ADDR_W-1:0]  base_addr,
  input  logic [ADDR_W-1:0]  stride,
  output logic [PHASE_W-1:0] phase_o,
  output logic [CNT_W-1:0]   count_o,
  output logic [1:0]         action_o,
  output logic [ADDR_W-1:0]  fetch_addr_o,
  output logic               plan_valid_o
);
  import vsp_pkg::*;

  logic               accept;
  logic [PHASE_W-1:0] phase_c;
  logic [CNT_W-1:0]   count_c;
  act_e               act_c;
  logic [ADDR_W-1:0]  jump_addr, seq_addr;

  assign accept = line_stb && !frame_start;

  vsp_phase_acc #(.INT_W(INT_W), .FRAC_W(FRAC_W), .PHASE_W(PHASE_W)) u_acc (
    .clk(clk), .rst(rst), .step(accept), .restart(frame_start),
    .inc_int(inc_int), .inc_frac(inc_frac), .phase(phase_c), .count(count_c));

  vsp_fetch_decide #(.CNT_W(CNT_W), .TAPS(TAPS)) u_dec (
    .count(count_c), .act(act_c));

  vsp_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .TAPS(TAPS)) u_addr (
    .clk(clk), .rst(rst), .step(accept), .restart(frame_start),
    .base(base_addr), .stride(stride), .count(count_c),
    .jump_addr(jump_addr), .seq_addr(seq_addr));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_o      <= '0;
      count_o      <= '0;
      action_o     <= ACT_REUSE;
      fetch_addr_o <= '0;
      plan_valid_o <= 1'b0;
    end else begin
      plan_valid_o <= accept;
      if (accept) begin
        phase_o      <= phase_c;
        count_o      <= count_c;
        action_o     <= act_c;
        fetch_addr_o <= (act_c == ACT_JUMP) ? jump_addr : seq_addr;
      end
    end
  end

  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !plan_valid_o);
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !accept |=> ($stable(count_o) && $stable(fetch_addr_o) && $stable(phase_o)));
  assert_reuse_R5: assert property (@(posedge clk) disable iff (rst)
    (plan_valid_o && count_o == '0) |-> (action_o == ACT_REUSE));
  assert_next_R6: assert property (@(posedge clk) disable iff (rst)
    (plan_valid_o && count_o != '0 && count_o < CNT_W'(TAPS)) |-> (action_o == ACT_NEXT));
  assert_jump_R7: assert property (@(posedge clk) disable iff (rst)
    (plan_valid_o && count_o >= CNT_W'(TAPS)) |-> (action_o == ACT_JUMP));
  assert_count_R4: assert property (@(posedge clk) disable iff (rst)
    accept |=> (count_o >= CNT_W'($past(inc_int)) && count_o <= CNT_W'($past(inc_int)) + 1'b1));
endmodule

// File: tb/vscale_fetch_planner_test.sv
module vscale_fetch_planner_test;
  logic        clk = 0;
  logic        rst, frame_start, line_stb;
  logic [3:0]  inc_int;
  logic [15:0] inc_frac;
  logic [31:0] base_addr, stride;
  logic [4:0]  phase_o, count_o;
  logic [1:0]  action_o;
  logic [31:0] fetch_addr_o;
  logic        plan_valid_o;

  int total = 0, bad = 0;
  logic [15:0] m_frac;
  logic [31:0] m_line;

  always #2.5 clk = ~clk;

  vscale_fetch_planner uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stb(logic [3:0] ii, logic [15:0] ff);
    logic [16:0] s;
    logic [4:0]  n;
    logic [31:0] ea;
    logic [1:0]  ec;
    s  = {1'b0, m_frac} + {1'b0, ff};
    n  = {1'b0, ii} + {4'd0, s[16]};
    ec = (n == 0) ? 2'd0 : (n < 5) ? 2'd1 : 2'd2;
    ea = (n >= 5) ? m_line + 32'(n) * stride : m_line + 32'd5 * stride;
    @(negedge clk);
    inc_int = ii; inc_frac = ff; line_stb = 1;
    @(negedge clk);
    line_stb = 0;
    chk("R2 phase", 32'(phase_o), 32'(m_frac[15:11]));
    chk("R4 count", 32'(count_o), 32'(n));
    chk("R5/R6/R7 action", 32'(action_o), 32'(ec));
    chk("R6/R7/R8 fetch address", fetch_addr_o, ea);
    chk("R10 valid pulse", 32'(plan_valid_o), 1);
    m_frac = s[15:0];
    m_line = m_line + 32'(n) * stride;
  endtask

  task automatic start_frame(logic [31:0] b, logic [31:0] st);
    @(negedge clk);
    base_addr = b; stride = st; frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    m_line = b; m_frac = 0;
  endtask

  task automatic t_reset;
    chk("R1 phase", 32'(phase_o), 0);
    chk("R1 count", 32'(count_o), 0);
    chk("R1 action", 32'(action_o), 0);
    chk("R1 addr", fetch_addr_o, 0);
    chk("R1 valid", 32'(plan_valid_o), 0);
  endtask

  task automatic t_upscale;   // step 0.25: R3 accumulation, R5 reuse then R6 on carry
    start_frame(32'd1000, 32'd64);
    for (int i = 0; i < 6; i++) stb(4'd0, 16'h4000);
  endtask

  task automatic t_integer;   // step 2.0 and 3.75: R6 sequential fetch, R8 advance
    start_frame(32'h0001_0000, 32'd720);
    for (int i = 0; i < 3; i++) stb(4'd2, 16'h0000);
    for (int i = 0; i < 3; i++) stb(4'd3, 16'hC000);
  endtask

  task automatic t_jump;      // R7 jump with count 5, 6 and the maximum 16
    start_frame(32'd4096, 32'd1920);
    stb(4'd5, 16'h8000);
    stb(4'd5, 16'h8000);
    stb(4'd4, 16'hFFFF);
    stb(4'd15, 16'hFFFF);
  endtask

  task automatic t_hold;      // R10 outputs hold and valid drops without a strobe
    logic [31:0] a; logic [4:0] c, p;
    a = fetch_addr_o; c = count_o; p = phase_o;
    repeat (6) @(negedge clk);
    chk("R10 valid low", 32'(plan_valid_o), 0);
    chk("R10 addr hold", fetch_addr_o, a);
    chk("R10 count hold", 32'(count_o), 32'(c));
    chk("R10 phase hold", 32'(phase_o), 32'(p));
    stb(4'd0, 16'h1234);      // R3 fraction untouched by idle cycles
  endtask

  task automatic t_override;  // R9 frame start beats a simultaneous strobe
    logic [31:0] a;
    a = fetch_addr_o;
    @(negedge clk);
    base_addr = 32'd500; stride = 32'd10; frame_start = 1; line_stb = 1;
    inc_int = 4'd7; inc_frac = 16'hFFFF;
    @(negedge clk);
    frame_start = 0; line_stb = 0;
    chk("R9 no plan", 32'(plan_valid_o), 0);
    chk("R9 addr unchanged", fetch_addr_o, a);
    m_line = 32'd500; m_frac = 0;
    stb(4'd1, 16'h0800);
    stb(4'd6, 16'h0000);
  endtask

  initial begin
    #(5.0 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; frame_start = 0; line_stb = 0; inc_int = 0; inc_frac = 0;
    base_addr = 0; stride = 0; m_frac = 0; m_line = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_upscale();
    t_integer();
    t_jump();
    t_hold();
    t_override();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule